// File: doc/BRIEF.md
# Priority Address Window Translator

This block sits between a local bus master and a PCI bus interface. It turns each local-bus address into a PCI address and a PCI cycle type. It does this through three programmable windows. Two of them are general memory windows. Each has a base register, which sets the local address, a power-of-two size, a prefetchable attribute and an enable. Each also has a map register, which sets the upper PCI address bits, the cycle type to issue and whether the two lowest address bits pass through. The third window has a fixed size of 16 MB, always issues I/O cycles and has a narrower register layout.

Windows may overlap. When they do, the enabled window with the lowest number wins. Software uses this to hide one window behind a larger one and then reprogram the hidden window, for example to reach configuration space for a short time. Window registers are loaded through a plain write port. A request is a 32-bit address with a valid strobe. One clock later the block returns a hit with the translated address, the cycle type, the prefetch attribute and the winning window number, or a miss with every other field at zero.

Top module: `addr_window_xlate`

## Requirements
- R1: A memory window (0 or 1) base register holds the local base address in bits 31:20, a size code in bits 7:4, prefetchable in bit 3, a swap field in bits 9:8 that has no effect on translation, and enable in bit 0. The window matches an address when it is enabled and the address bits above the window size equal the corresponding base bits.
- R2: The window size is 1 MB shifted left by the size code, for codes 0 to 11 (8 is 256 MB, 9 is 512 MB, 11 is 2 GB). A memory window whose size code is 12 to 15 never matches.
- R3: A memory window map register (bits 15:4 are PCI address bits 31:20) translates a hit as follows. PCI address bits at or above the window size come from the map register, and the bits below the window size are copied from the local address.
- R4: Bits 3:1 of a memory window map register are driven out unchanged as the cycle type (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory multiple).
- R5: When map bit 0 of the winning memory window is 0, PCI address bits 1:0 are 00. When it is 1, they equal local address bits 1:0.
- R6: When several enabled windows match, the lowest-numbered one is used and reported on rsp_win (0, 1 or 2).
- R7: Window 2 works as follows. Base register bits 15:8 hold local address bits 31:24, bits 7:6 are a swap field with no effect, and bit 0 is enable. The window is 16 MB. Map register bits 15:8 supply PCI address bits 31:24, and local bits 23:0 pass through unchanged, including bits 1:0. The cycle type is 001 and the prefetch output is 0.
- R8: A request that matches no window gives rsp_miss=1 and rsp_hit=0, with rsp_addr, rsp_cycle and rsp_prefetch all 0.
- R9: The result of a request sampled at one rising edge appears on the outputs after that edge and holds for one cycle. When no request is sampled, rsp_valid, rsp_hit and rsp_miss are 0.
- R10: A register write affects requests sampled from the next edge onward. A request sampled at the same edge as the write uses the old contents.
- R11: Reset clears every window register, so after reset no window matches and all outputs are 0.
- R12: rsp_prefetch equals base bit 3 of the winning memory window.
- R13: The write selector cfg_sel picks the register: 0 is base 0, 1 is map 0, 2 is base 1, 3 is map 1, 4 is base 2 and 5 is map 2. Map registers and the window 2 base take cfg_data bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_data | input | 32 | Register write data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local-bus address to translate |
| rsp_valid | output | 1 | A result is present this cycle |
| rsp_hit | output | 1 | Some window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | 2 | Number of the winning window |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_cycle | output | 3 | PCI cycle type code |
| rsp_prefetch | output | 1 | Winning window is prefetchable |

## Verification
Every translation result is due exactly one rising edge after the request is sampled. Register contents become visible to requests sampled one edge after the write. The bench drives requests and writes on the falling edge and compares all outputs at the next falling edge, which is half a cycle after the result edge. The same-edge write case is checked by presenting a write and a request together and expecting the old mapping at that sample, then the new mapping on the following request.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int ADDR_W        = 32;
    localparam int MAP_W         = 16;
    localparam int MEM_SHIFT     = 20;
    localparam int IO_SHIFT      = 24;
    localparam int NUM_MEM_WIN   = 2;
    localparam int NUM_WIN       = NUM_MEM_WIN + 1;
    localparam int WIN_IDX_W     = $clog2(NUM_WIN);
    localparam int SEL_W         = $clog2(2 * NUM_WIN);
    localparam int CODE_W        = 4;
    localparam int MAX_SIZE_CODE = 11;
    localparam int CYC_W         = 3;

    typedef enum logic [CYC_W-1:0] {
        CYC_IACK   = 3'b000,
        CYC_IO     = 3'b001,
        CYC_MEM    = 3'b011,
        CYC_CFG    = 3'b101,
        CYC_MEMMUL = 3'b110
    } cyc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [MAP_W-1:0]  map;
    } mem_win_cfg_t;

    typedef struct packed {
        logic [MAP_W-1:0] base;
        logic [MAP_W-1:0] map;
    } io_win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [CYC_W-1:0]  cyc;
        logic              pf;
    } win_res_t;

    // Ones on every address bit at or above the window size.
    function automatic logic [ADDR_W-1:0] upper_mask(input logic [CODE_W-1:0] code);
        return {ADDR_W{1'b1}} << (MEM_SHIFT + int'(code));
    endfunction

    function automatic logic size_legal(input logic [CODE_W-1:0] code);
        return int'(code) <= MAX_SIZE_CODE;
    endfunction

    // Map register upper field placed at PCI address bits 31:20.
    function automatic logic [ADDR_W-1:0] mem_pci_top(input logic [MAP_W-1:0] map);
        return {map[MAP_W-1:4], {MEM_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/xw_regs.sv
module xw_regs
    import xw_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [ADDR_W-1:0]        cfg_data,
    output mem_win_cfg_t             mem_cfg [NUM_MEM_WIN],
    output io_win_cfg_t              io_cfg
);

    for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_mem
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_cfg[g] <= '0;
            end else if (cfg_we) begin
                if (cfg_sel == SEL_W'(2 * g))
                    mem_cfg[g].base <= cfg_data;
                if (cfg_sel == SEL_W'(2 * g + 1))
                    mem_cfg[g].map <= cfg_data[MAP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_cfg <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_W'(2 * NUM_MEM_WIN))
                io_cfg.base <= cfg_data[MAP_W-1:0];
            if (cfg_sel == SEL_W'(2 * NUM_MEM_WIN + 1))
                io_cfg.map <= cfg_data[MAP_W-1:0];
        end
    end

endmodule

// File: rtl/xw_mem_match.sv
module xw_mem_match
    import xw_pkg::*;
(
    input  mem_win_cfg_t       cfg,
    input  logic [ADDR_W-1:0]  addr,
    output win_res_t           res
);

    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] pci;

    always_comb begin
        code = cfg.base[7:4];
        mask = upper_mask(code);
        pci  = (mem_pci_top(cfg.map) & mask) | (addr & ~mask);
        if (!cfg.map[0])
            pci[1:0] = 2'b00;
        res.hit  = cfg.base[0] && size_legal(code)
                   && ((addr & mask) == (cfg.base & mask));
        res.addr = pci;
        res.cyc  = cfg.map[3:1];
        res.pf   = cfg.base[3];
    end

endmodule

// File: rtl/xw_io_match.sv
module xw_io_match
    import xw_pkg::*;
(
    input  io_win_cfg_t        cfg,
    input  logic [ADDR_W-1:0]  addr,
    output win_res_t           res
);

    localparam int HI_W = ADDR_W - IO_SHIFT;

    logic unused_io_bits;
    assign unused_io_bits = ^{cfg.base[MAP_W-HI_W-1:1], cfg.map[MAP_W-HI_W-1:0]};

    always_comb begin
        res.hit  = cfg.base[0]
                   && (addr[ADDR_W-1:IO_SHIFT] == cfg.base[MAP_W-1:MAP_W-HI_W]);
        res.addr = {cfg.map[MAP_W-1:MAP_W-HI_W], addr[IO_SHIFT-1:0]};
        res.cyc  = CYC_IO;
        res.pf   = 1'b0;
    end

endmodule

// File: rtl/xw_select.sv
module xw_select
    import xw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  win_res_t              res [NUM_WIN],
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic [WIN_IDX_W-1:0]  rsp_win,
    output logic [ADDR_W-1:0]     rsp_addr,
    output logic [CYC_W-1:0]      rsp_cycle,
    output logic                  rsp_prefetch
);

    logic                 found;
    logic [WIN_IDX_W-1:0] pick_idx;
    win_res_t             pick;

    // Ascending scan: the first hit is kept.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        pick     = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (!found && res[i].hit) begin
                found    = 1'b1;
                pick_idx = WIN_IDX_W'(i);
                pick     = res[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_win      <= '0;
            rsp_addr     <= '0;
            rsp_cycle    <= '0;
            rsp_prefetch <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && found;
            rsp_miss  <= req_valid && !found;
            if (req_valid && found) begin
                rsp_win      <= pick_idx;
                rsp_addr     <= pick.addr;
                rsp_cycle    <= pick.cyc;
                rsp_prefetch <= pick.pf;
            end else begin
                rsp_win      <= '0;
                rsp_addr     <= '0;
                rsp_cycle    <= '0;
                rsp_prefetch <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import xw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [ADDR_W-1:0]     cfg_data,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic [WIN_IDX_W-1:0]  rsp_win,
    output logic [ADDR_W-1:0]     rsp_addr,
    output logic [CYC_W-1:0]      rsp_cycle,
    output logic                  rsp_prefetch
);

    mem_win_cfg_t mem_cfg [NUM_MEM_WIN];
    io_win_cfg_t  io_cfg;
    win_res_t     win_res [NUM_WIN];

    xw_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .mem_cfg  (mem_cfg),
        .io_cfg   (io_cfg)
    );

    for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_match
        xw_mem_match u_mem (
            .cfg  (mem_cfg[g]),
            .addr (req_addr),
            .res  (win_res[g])
        );
    end

    xw_io_match u_io (
        .cfg  (io_cfg),
        .addr (req_addr),
        .res  (win_res[NUM_MEM_WIN])
    );

    xw_select u_sel (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .res          (win_res),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_miss     (rsp_miss),
        .rsp_win      (rsp_win),
        .rsp_addr     (rsp_addr),
        .rsp_cycle    (rsp_cycle),
        .rsp_prefetch (rsp_prefetch)
    );

endmodule

// File: rtl/xw_chk.sv
module xw_chk
    import xw_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_we,
    input logic [SEL_W-1:0]      cfg_sel,
    input logic [ADDR_W-1:0]     cfg_data,
    input logic                  req_valid,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic                  rsp_miss,
    input logic [WIN_IDX_W-1:0]  rsp_win,
    input logic [ADDR_W-1:0]     rsp_addr,
    input logic [CYC_W-1:0]      rsp_cycle,
    input logic                  rsp_prefetch
);

    logic unused_chk;
    assign unused_chk = ^{cfg_we, cfg_sel, cfg_data};

    // R9
    a_r9_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R9
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

    // R8
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    // R8
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_addr == '0 && rsp_cycle == '0 && !rsp_prefetch));

    // R7
    a_r7_io_window: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && rsp_win == WIN_IDX_W'(NUM_MEM_WIN)) |->
        (rsp_cycle == CYC_IO && !rsp_prefetch
         && rsp_addr[IO_SHIFT-1:0] == $past(req_addr[IO_SHIFT-1:0])));

    // R3
    a_r3_offset_pass: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && rsp_win < WIN_IDX_W'(NUM_MEM_WIN)) |->
        (rsp_addr[MEM_SHIFT-1:2] == $past(req_addr[MEM_SHIFT-1:2])));

    // R11
    a_r11_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !rsp_hit && !rsp_miss));

endmodule

bind addr_window_xlate xw_chk u_xw_chk (.*);

// File: tb/tb_addr_window_xlate.sv
module tb_addr_window_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_prefetch;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] sh_base [2];
    logic [15:0] sh_map  [2];
    logic [15:0] sh_iob, sh_iom;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_xlate dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_cycle(rsp_cycle),
        .rsp_prefetch(rsp_prefetch)
    );

    task automatic shadow_write(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: sh_base[0] = d;
            3'd1: sh_map[0]  = d[15:0];
            3'd2: sh_base[1] = d;
            3'd3: sh_map[1]  = d[15:0];
            3'd4: sh_iob     = d[15:0];
            3'd5: sh_iom     = d[15:0];
            default: ;
        endcase
    endtask

    // Expected result computed arithmetically from the requirements.
    task automatic model(input logic [31:0] a, output logic eh, output logic [1:0] ew,
                         output logic [31:0] ea, output logic [2:0] ec, output logic ep);
        longint unsigned sz, st, off, top;
        eh = 0; ew = 0; ea = 0; ec = 0; ep = 0;
        for (int w = 0; w < 2; w++) begin
            if (!eh && sh_base[w][0] && sh_base[w][7:4] <= 4'd11) begin
                sz = 64'd1 << (20 + int'(sh_base[w][7:4]));
                st = ({32'd0, sh_base[w]} & 64'hFFF0_0000) / sz * sz;
                if ({32'd0, a} >= st && {32'd0, a} < st + sz) begin
                    eh  = 1;
                    ew  = 2'(w);
                    off = {32'd0, a} % sz;
                    top = {32'd0, sh_map[w][15:4], 20'h0} / sz * sz;
                    ea  = 32'(top + off);
                    if (!sh_map[w][0]) ea[1:0] = 2'b00;
                    ec  = sh_map[w][3:1];
                    ep  = sh_base[w][3];
                end
            end
        end
        if (!eh && sh_iob[0]) begin
            st = {32'd0, sh_iob[15:8], 24'h0};
            if ({32'd0, a} >= st && {32'd0, a} < st + 64'h100_0000) begin
                eh = 1; ew = 2'd2;
                ea = 32'({32'd0, sh_iom[15:8], 24'h0} + ({32'd0, a} - st));
                ec = 3'b001; ep = 0;
            end
        end
    endtask

    task automatic compare(input string tag, input logic [31:0] a, input logic eh,
                           input logic [1:0] ew, input logic [31:0] ea,
                           input logic [2:0] ec, input logic ep);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh
            || (eh && rsp_win !== ew) || rsp_addr !== ea
            || rsp_cycle !== ec || rsp_prefetch !== ep) begin
            errors++;
            $display("FAIL %s addr=%h got v=%b hit=%b miss=%b win=%0d pci=%h cyc=%b pf=%b exp hit=%b win=%0d pci=%h cyc=%b pf=%b",
                     tag, a, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_addr, rsp_cycle,
                     rsp_prefetch, eh, ew, ea, ec, ep);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
        shadow_write(sel, d);
    endtask

    task automatic xl(input logic [31:0] a, input string tag);
        logic eh, ep; logic [1:0] ew; logic [31:0] ea; logic [2:0] ec;
        model(a, eh, ew, ea, ec, ep);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        compare(tag, a, eh, ew, ea, ec, ep);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0) begin
            errors++;
            $display("FAIL %s idle got v=%b hit=%b miss=%b exp 0 0 0", tag, rsp_valid, rsp_hit, rsp_miss);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog got no completion after %0d cycles exp completion", WATCHDOG);
        finish_run();
    end

    initial begin
        logic eh, ep; logic [1:0] ew; logic [31:0] ea; logic [2:0] ec;
        longint unsigned sz;
        for (int w = 0; w < 2; w++) begin sh_base[w] = 0; sh_map[w] = 0; end
        sh_iob = 0; sh_iom = 0;

        repeat (3) @(negedge clk);
        rst = 0;
        idle_check("R11");
        xl(32'h4000_0000, "R11");
        xl(32'h0000_0000, "R8");
        idle_check("R9");

        // R1 R2 R3: size code sweep on window 0, swap bits set
        for (int c = 0; c < 16; c++) begin
            wr(3'd0, 32'h4000_0301 | (c << 4));
            wr(3'd1, 32'h0000_ABC7);
            sz = 64'd1 << (20 + c);
            xl(32'h4000_0000, "R2");
            xl(32'(64'h4000_0000 + sz - 1), "R2");
            xl(32'(64'h4000_0000 + sz), "R2");
            xl(32'h3FFF_FFFF, "R1");
            xl(32'h4765_4321, "R3");
        end

        // R4 R5: every cycle type value and both low-bit settings
        wr(3'd0, 32'h4000_0081);
        for (int t = 0; t < 8; t++) begin
            for (int lo = 0; lo < 2; lo++) begin
                wr(3'd1, {16'h0, 12'h123, 3'(t), 1'(lo)});
                xl(32'h4ABC_DEF7, "R4");
                xl(32'h4000_0003, "R5");
            end
        end

        // R12: prefetch attribute on window 1
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h5000_0089);
        wr(3'd3, 32'h0000_100D);
        xl(32'h5123_4568, "R12");
        wr(3'd2, 32'h5000_0081);
        xl(32'h5123_4568, "R12");

        // R6: overlapping windows, lowest number wins
        wr(3'd0, 32'h4000_0091);
        wr(3'd1, 32'h0000_0006);
        wr(3'd2, 32'h5000_0089);
        wr(3'd3, 32'h0000_100D);
        xl(32'h5000_0010, "R6");
        xl(32'h4000_0010, "R6");
        wr(3'd0, 32'h4000_0081);
        xl(32'h5000_0010, "R6");
        wr(3'd0, 32'h4000_0090);
        xl(32'h5000_0010, "R6");

        // R10: write and request on the same edge
        wr(3'd0, 32'h4000_0091);
        @(negedge clk);
        model(32'h5000_0040, eh, ew, ea, ec, ep);
        cfg_we = 1; cfg_sel = 3'd0; cfg_data = 32'h4000_0081;
        req_valid = 1; req_addr = 32'h5000_0040;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        shadow_write(3'd0, 32'h4000_0081);
        compare("R10", 32'h5000_0040, eh, ew, ea, ec, ep);
        xl(32'h5000_0040, "R10");

        // R13: selector routing and window 2 overlap with memory window
        wr(3'd4, 32'h0000_50C1);
        wr(3'd5, 32'h0000_7700);
        xl(32'h50AB_CDEF, "R13");
        wr(3'd2, 32'h0);
        xl(32'h50AB_CDEF, "R13");

        // R7: window 2 base sweep over all 256 positions
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h0000_34FF);
        for (int k = 0; k < 256; k++) begin
            wr(3'd4, {16'h0, 8'(k), 8'hC1});
            xl({8'(k), 24'hF0_0D03}, "R7");
            xl({8'(k) ^ 8'h01, 24'h00_0001}, "R7");
        end
        wr(3'd4, 32'h0000_6000);
        xl(32'h6000_0000, "R8");
        idle_check("R9");

        finish_run();
    end

endmodule